// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits of a four-beat burst. When a burst is opened by one of two active-low address-status strobes, it captures the low bits of the external address as the burst's start value. Each later cycle with the advance input low and both strobes idle moves the burst one beat on. With advance high the burst holds its beat. The registered upper address is joined to these bits outside this block.

A mode input picks the beat ordering. Linear ordering adds the beat count to the start value, modulo the burst length. Interleaved ordering XORs the start value with the beat count. The mode is applied without a register, so a change shows up on the output in the same cycle with the same beat count. A strobe counts as a burst start only while the select input is high. A strobe seen while select is low has no effect, and since a strobe is present it also does not advance the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the start value and the beat count, so `eff_low` is 2'b00 after that edge in either mode.
- R2: At a rising edge where `sel_ok` is 1 and `proc_stb_n` or `ctrl_stb_n` is 0, `ext_low` is captured as the start value and the beat count returns to zero, so `eff_low` equals the captured `ext_low` after that edge whatever the values of `adv_n` and `ilv_mode`.
- R3: With `ilv_mode` = 0 (linear), each step makes `eff_low` the previous value plus one modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `ilv_mode` = 1 (interleaved), `eff_low` is the start value XOR the beat count. From 00 the order is 00,01,10,11. From 01 it is 01,00,11,10. From 10 it is 10,11,00,01. From 11 it is 11,10,01,00.
- R5: A step happens only at an edge where `adv_n` is 0 and both strobes are 1. With `adv_n` = 1 and no accepted strobe, `eff_low` keeps its value.
- R6: A strobe at an edge where `sel_ok` is 0 neither loads nor steps, so `eff_low` keeps its value even with `adv_n` = 0.
- R7: After four steps from a start value, `eff_low` is back at the start value and the sequence repeats.
- R8: Changing `ilv_mode` changes `eff_low` in the same cycle without changing the beat count. For example, start 01 at beat 3 gives 10 in interleaved mode and 00 in linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_stb_n | input | 1 | First address-status strobe, active low |
| ctrl_stb_n | input | 1 | Second address-status strobe, active low |
| sel_ok | input | 1 | High when a strobe at this edge may start a burst |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_low | input | CNT_W | Low bits of the external address |
| eff_low | output | CNT_W | Effective low address bits for the current beat |

## Verification
Full bursts are run from several start values in both orderings. Linear runs from 01 tell an adder apart from an XOR, because the two orders differ there. Interleaved runs from 10, 11 and 01 show that the XOR is applied to the start value and not only to the beat count. Each strobe is used alone to load a burst. A strobe is also given with select low while advance is asserted, which separates "ignored" from both "load" and "step". Holds, a mode flip at beat 3, a load with advance held low, and a reset from the middle of a burst each isolate one control path.

// File: rtl/burst_seq_pkg.sv
// Package: shared ordering type for the burst address sequencer.
// Assumes: mode 0 selects linear and mode 1 selects interleaved order.
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;
endpackage

// File: rtl/burst_seq_ctl.sv
// Module: burst_seq_ctl
// Decodes the strobes, select and advance into a load pulse and a step pulse.
// Assumes: all inputs are already synchronous to the block clock. Load and
// step can never be high together, because a step needs both strobes idle.
module burst_seq_ctl (
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    input  logic sel_ok,
    input  logic adv_n,
    output logic load,
    output logic step
);
    logic any_stb;

    // Purpose: flag a strobe on either address-status input.
    always_comb begin
        any_stb = !proc_stb_n || !ctrl_stb_n;
    end

    // Purpose: accept a strobe only while selected; step only while no strobe is present.
    always_comb begin
        load = any_stb && sel_ok;
        step = !any_stb && !adv_n;
    end
endmodule

// File: rtl/burst_seq_state.sv
// Module: burst_seq_state
// Holds the captured start value and the free-running beat count.
// Assumes: load and step are mutually exclusive. The reset is synchronous
// and active low.
module burst_seq_state #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] ext_low,
    output logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] beat_q
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    // Purpose: capture the start value on a load, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    start_q <= ZERO;
        else if (load) start_q <= ext_low;
    end

    // Purpose: clear the beat count on a load and count up on each step, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)    beat_q <= ZERO;
        else if (load) beat_q <= ZERO;
        else if (step) beat_q <= beat_q + ONE;
    end
endmodule

// File: rtl/burst_seq_order.sv
// Module: burst_seq_order
// Combines the start value and the beat count into the effective low bits,
// in linear or interleaved order.
// Assumes: the mode may change at any time. The result is purely combinational.
module burst_seq_order
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_order_t     order,
    input  logic [CNT_W-1:0] start_q,
    input  logic [CNT_W-1:0] beat_q,
    output logic [CNT_W-1:0] eff_low
);
    logic [CNT_W-1:0] ilv_addr;
    logic [CNT_W-1:0] lin_addr;

    // Interleaved order: each bit is flipped by the matching beat bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
        assign ilv_addr[b] = start_q[b] ^ beat_q[b];
    end

    // Purpose: linear order, start plus beat modulo the burst length.
    always_comb begin
        lin_addr = start_q + beat_q;
    end

    // Purpose: select the ordering named by the mode.
    always_comb begin
        eff_low = (order == ORD_INTERLEAVE) ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer: loads the low address bits on an accepted strobe,
// steps through a 2**CNT_W beat burst on advance, holds otherwise, and
// orders the beats linearly or interleaved depending on ilv_mode.
// Assumes: one clock domain, synchronous active-low reset, and an upper
// address register outside this block.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             sel_ok,
    input  logic             adv_n,
    input  logic             ilv_mode,
    input  logic [CNT_W-1:0] ext_low,
    output logic [CNT_W-1:0] eff_low
);
    logic             load;
    logic             step;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] beat_q;
    burst_order_t     order;

    // Purpose: map the mode pin onto the ordering type.
    always_comb begin
        order = ilv_mode ? ORD_INTERLEAVE : ORD_LINEAR;
    end

    burst_seq_ctl u_ctl (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sel_ok     (sel_ok),
        .adv_n      (adv_n),
        .load       (load),
        .step       (step)
    );

    burst_seq_state #(.CNT_W(CNT_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .ext_low (ext_low),
        .start_q (start_q),
        .beat_q  (beat_q)
    );

    burst_seq_order #(.CNT_W(CNT_W)) u_order (
        .order   (order),
        .start_q (start_q),
        .beat_q  (beat_q),
        .eff_low (eff_low)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Property checker for burst_addr_seq, attached by bind. It works only from
// the top-level ports and keeps its own record of the last loaded start value
// and of the steps taken since that load.
module burst_addr_seq_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             proc_stb_n,
    input logic             ctrl_stb_n,
    input logic             sel_ok,
    input logic             adv_n,
    input logic             ilv_mode,
    input logic [CNT_W-1:0] ext_low,
    input logic [CNT_W-1:0] eff_low
);
    logic             c_load;
    logic             c_step;
    logic             c_ign;
    logic             seen;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] nsteps;

    // Purpose: classify each edge from the interface rules.
    always_comb begin
        c_load = sel_ok && (!proc_stb_n || !ctrl_stb_n);
        c_step = proc_stb_n && ctrl_stb_n && !adv_n;
        c_ign  = !sel_ok && (!proc_stb_n || !ctrl_stb_n);
    end

    // Purpose: remember the last loaded start value and count the steps since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen   <= 1'b0;
            ld_val <= '0;
            nsteps <= '0;
        end else if (c_load) begin
            seen   <= 1'b1;
            ld_val <= ext_low;
            nsteps <= '0;
        end else if (c_step) begin
            nsteps <= nsteps + CNT_W'(1);
        end
    end

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_load |=> (eff_low == $past(ext_low)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_step && !ilv_mode) |=> (ilv_mode || eff_low == CNT_W'($past(eff_low) + 1'b1)));

    // R4: in interleaved order the beat count's low bit flips on every step, so output bit 0 toggles.
    assert_ilv_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_step && ilv_mode) |=> (!ilv_mode || eff_low[0] != $past(eff_low[0])));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && proc_stb_n && ctrl_stb_n) |=>
        (ilv_mode != $past(ilv_mode) || eff_low == $past(eff_low)));

    assert_ignored_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_ign |=> (ilv_mode != $past(ilv_mode) || eff_low == $past(eff_low)));

    assert_wrap_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && nsteps == '0) |-> (eff_low == ld_val));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .sel_ok     (sel_ok),
    .adv_n      (adv_n),
    .ilv_mode   (ilv_mode),
    .ext_low    (ext_low),
    .eff_low    (eff_low)
);

// File: tb/test_burst_addr_seq.sv
// Bench for burst_addr_seq: walks a vector table, then runs directed reset and
// interleaved-from-zero tests. Inputs change on the falling edge and outputs
// are checked on the next falling edge, after one rising edge.
module test_burst_addr_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       proc_stb_n = 1'b1;
    logic       ctrl_stb_n = 1'b1;
    logic       sel_ok = 1'b1;
    logic       adv_n = 1'b1;
    logic       ilv_mode = 1'b0;
    logic [1:0] ext_low = 2'b00;
    logic [1:0] eff_low;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.CNT_W(2)) i_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sel_ok     (sel_ok),
        .adv_n      (adv_n),
        .ilv_mode   (ilv_mode),
        .ext_low    (ext_low),
        .eff_low    (eff_low)
    );

    // Vector layout: [8] proc_stb_n [7] ctrl_stb_n [6] sel_ok [5] adv_n
    // [4] ilv_mode [3:2] ext_low [1:0] expected eff_low after the edge.
    localparam int NV = 23;
    localparam logic [8:0] VEC [NV] = '{
        9'b0_1_1_1_0_01_01, // R2 load 01 by first strobe
        9'b1_1_1_0_0_00_10, // R3 linear step
        9'b1_1_1_0_0_00_11, // R3
        9'b1_1_1_0_0_00_00, // R3 wrap in value
        9'b1_1_1_0_0_00_01, // R7 back to start
        9'b1_1_1_1_0_00_01, // R5 hold
        9'b1_0_1_1_1_10_10, // R2 load 10 by second strobe
        9'b1_1_1_0_1_00_11, // R4 interleaved from 10
        9'b1_1_1_0_1_00_00, // R4
        9'b1_1_1_0_1_00_01, // R4
        9'b1_1_1_0_1_00_10, // R7 back to start
        9'b0_1_1_1_1_11_11, // R2 load 11
        9'b1_1_1_0_1_00_10, // R4 interleaved from 11
        9'b1_1_1_0_1_00_01, // R4
        9'b1_1_1_0_1_00_00, // R4
        9'b0_1_1_1_1_01_01, // R2 load 01
        9'b1_1_1_0_1_00_00, // R4 interleaved from 01
        9'b1_1_1_0_1_00_11, // R4
        9'b1_1_1_0_1_00_10, // R4
        9'b0_0_0_0_1_00_10, // R6 strobes while deselected: no load, no step
        9'b1_1_1_1_0_00_00, // R8 mode flip at beat 3: 01+11
        9'b0_1_1_0_0_11_11, // R2 load wins while adv_n is low
        9'b1_1_1_0_0_00_00  // R3 step after load
    };
    localparam int VREQ [NV] = '{2,3,3,3,7,5,2,4,4,4,7,2,4,4,4,2,4,4,4,6,8,2,3};

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (eff_low !== exp) begin
            failures++;
            $display("FAIL %s eff_low actual=%b expected=%b", req, eff_low, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        tick();
        tick();
        check("R1 reset", 2'b00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            proc_stb_n = VEC[i][8];
            ctrl_stb_n = VEC[i][7];
            sel_ok     = VEC[i][6];
            adv_n      = VEC[i][5];
            ilv_mode   = VEC[i][4];
            ext_low    = VEC[i][3:2];
            tick();
            check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][1:0]);
        end

        // R8: the same beat re-evaluated without a clock edge (start 11, beat 1).
        ilv_mode = 1'b1;
        #1;
        check("R8 immediate mode flip", 2'b10);
        ilv_mode = 1'b0;
        #1;
        check("R8 immediate mode flip back", 2'b00);

        // R1: reset from the middle of a burst, in interleaved mode.
        ilv_mode = 1'b1;
        adv_n = 1'b0;
        rst_n = 1'b0;
        tick();
        check("R1 mid-burst reset", 2'b00);
        rst_n = 1'b1;
        tick();
        check("R4 interleaved from reset start 00", 2'b01);
        tick();
        check("R4 interleaved from reset start 00", 2'b10);
        tick();
        check("R4 interleaved from reset start 00", 2'b11);
        tick();
        check("R7 wrap to 00", 2'b00);
        adv_n = 1'b1;
        tick();
        check("R5 hold after wrap", 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule